// File: doc/BRIEF.md
# Real-Time Clock Byte Register Interface

This block is the register side of a real-time clock. It sits behind a byte-level serial target and does no bit-level signalling of its own. It takes four kinds of bus event: a start for a write transfer, a start for a read transfer, a received write byte and a request for a read byte. From these it maintains a 16-entry byte register space. Entries 0 to 6 present the time and calendar in BCD. Entries 7 to 15 are plain control and scratch bytes. Bit 5 of entry 15 selects the hour format.

An internal timekeeper counts seconds on a one-pulse-per-second input and carries into minutes, hours, weekday, day of month, month and a two-digit year. When a read transfer starts, the current time is copied into shadow entries 0 to 6, and all reads come from those shadows. The whole multi-byte read therefore sees one consistent instant. Writes to entries 0 to 6 go straight into the running timekeeper.

Top module: `rtc_regfile`

## Requirements
- R1: A 4-bit register pointer selects the entry. It advances by one after every data byte written and every byte read, and wraps from 15 to 0.
- R2: The first byte after a write start is an address byte. Bits 7:4 load the pointer and bits 3:0 appear on `xfer_fmt`. No register entry is changed by it, and the pointer does not advance for it.
- R3: A read start sets the pointer to 15. The first byte read is entry 15 and the second is entry 0.
- R4: Shadow entries 0 to 6 change only on a read start. A time write or a seconds pulse after a read start leaves the bytes read back unchanged until the next read start.
- R5: In BCD, entry 0 is seconds, 1 is minutes, 4 is day of month, 5 is month (1 to 12) and 6 is year (00 to 99). On write, seconds and minutes use bits 6:0, day uses bits 5:0, month uses bits 4:0 and year uses all 8 bits.
- R6: When entry 15 bit 5 is 1, entry 2 holds the hour 00 to 23 in BCD, and a write to it uses bits 5:0.
- R7: When entry 15 bit 5 is 0, entry 2 holds 1 to 12 in BCD in bits 4:0 with bit 5 as the PM flag. Midnight reads 0x12, noon reads 0x32 and 13:00 reads 0x21. A write decodes the same form, so 0x12 sets hour 0 and 0x32 sets hour 12.
- R8: Entry 3 holds the weekday 1 to 7 in binary. A written value is read back and advances at each midnight, with 7 followed by 1.
- R9: A write to entries 7 to 15 stores the byte unchanged, and it is read back unchanged.
- R10: Each seconds pulse advances the time with full carry. Months have 28/29, 30 or 31 days, a year divisible by 4 is a leap year, December rolls to January, and year 99 rolls to 00.
- R11: Reset clears all 16 entries, the pointer, the format code and the address-byte flag. It also sets the time to 00:00:00, weekday 1, day 1, month 1, year 00.
- R12: A read request returns its byte on `rd_data` with `rd_valid` high in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| start_wr | input | 1 | Start of a write transfer |
| start_rd | input | 1 | Start of a read transfer |
| wr_valid | input | 1 | A write byte is present on wr_data |
| wr_data | input | 8 | Received write byte |
| rd_req | input | 1 | Request for the next read byte |
| rd_data | output | 8 | Returned read byte |
| rd_valid | output | 1 | rd_data holds a returned byte |
| xfer_fmt | output | 4 | Transfer-format code from the last address byte |

## Verification
The time registers are driven with values just before each carry boundary: end of minute, end of day, Feb 28 in a common year and in a leap year, Apr 30, and Dec 31 of year 99. Each boundary shows a different length or rollover rule in the carry chain. Hours are written in one format and read in the other at midnight, noon, 13:00, 23:00 and a morning hour, which separates the 12-hour encode path from the decode path. Bytes with their upper bits set show which write mask is applied to each field. Long reads past entry 15, a read after a time write without a new read start, and a read of entry 7 after an address byte separate pointer wrap, snapshot hold and address-byte handling.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_TIME = 7;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } rtc_time_t;

    typedef logic [NUM_TIME-1:0][BYTE_W-1:0] time_bytes_t;

    localparam rtc_time_t TIME_RESET = '{year: 7'd0, mon: 4'd1, mday: 5'd1,
                                         wday: 3'd1, hour: 5'd0, min: 6'd0,
                                         sec: 6'd0};

    function automatic logic [7:0] bin2bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v - tens * 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        logic [6:0] hi;
        logic [6:0] lo;
        hi = {3'b0, b[7:4]};
        lo = {3'b0, b[3:0]};
        return hi * 7'd10 + lo;
    endfunction

    function automatic logic [4:0] days_in_month(input logic [3:0] mon,
                                                 input logic [6:0] year);
        case (mon)
            4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

    function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic m24);
        if (m24)          return bin2bcd({2'b0, h});
        if (h == 5'd0)    return 8'h12;
        if (h < 5'd12)    return bin2bcd({2'b0, h});
        if (h == 5'd12)   return 8'h32;
        return 8'h20 | bin2bcd({2'b0, h - 5'd12});
    endfunction

    function automatic logic [4:0] dec_hour(input logic [7:0] d, input logic m24);
        logic [6:0] t;
        if (m24) begin
            t = bcd2bin({2'b0, d[5:0]});
        end else begin
            t = bcd2bin({3'b0, d[4:0]});
            if (d[5]) t = t + 7'd12;
            if (t == 7'd12)      t = 7'd0;
            else if (t == 7'd24) t = 7'd12;
        end
        return t[4:0];
    endfunction

    function automatic time_bytes_t pack_time(input rtc_time_t t, input logic m24);
        time_bytes_t b;
        b[0] = bin2bcd({1'b0, t.sec});
        b[1] = bin2bcd({1'b0, t.min});
        b[2] = enc_hour(t.hour, m24);
        b[3] = {5'b0, t.wday};
        b[4] = bin2bcd({2'b0, t.mday});
        b[5] = bin2bcd({3'b0, t.mon});
        b[6] = bin2bcd(t.year);
        return b;
    endfunction

endpackage

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_byte,
    input  logic       mode24,
    output rtc_time_t  now
);

    rtc_time_t cur;
    rtc_time_t adv;
    rtc_time_t nxt;

    // one-second advance with full calendar carry
    always_comb begin
        adv = cur;
        if (cur.sec == 6'd59) begin
            adv.sec = 6'd0;
            if (cur.min == 6'd59) begin
                adv.min = 6'd0;
                if (cur.hour == 5'd23) begin
                    adv.hour = 5'd0;
                    adv.wday = (cur.wday == 3'd7) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.mday == days_in_month(cur.mon, cur.year)) begin
                        adv.mday = 5'd1;
                        if (cur.mon == 4'd12) begin
                            adv.mon  = 4'd1;
                            adv.year = (cur.year == 7'd99) ? 7'd0 : cur.year + 7'd1;
                        end else begin
                            adv.mon = cur.mon + 4'd1;
                        end
                    end else begin
                        adv.mday = cur.mday + 5'd1;
                    end
                end else begin
                    adv.hour = cur.hour + 5'd1;
                end
            end else begin
                adv.min = cur.min + 6'd1;
            end
        end else begin
            adv.sec = cur.sec + 6'd1;
        end
    end

    // a field write takes priority over a coincident seconds pulse
    always_comb begin
        logic [6:0] v;
        v   = '0;
        nxt = cur;
        if (wr_en) begin
            case (wr_sel)
                3'd0: begin v = bcd2bin({1'b0, wr_byte[6:0]}); nxt.sec  = v[5:0]; end
                3'd1: begin v = bcd2bin({1'b0, wr_byte[6:0]}); nxt.min  = v[5:0]; end
                3'd2: nxt.hour = dec_hour(wr_byte, mode24);
                3'd3: nxt.wday = wr_byte[2:0];
                3'd4: begin v = bcd2bin({2'b0, wr_byte[5:0]}); nxt.mday = v[4:0]; end
                3'd5: begin v = bcd2bin({3'b0, wr_byte[4:0]}); nxt.mon  = v[3:0]; end
                3'd6: nxt.year = bcd2bin(wr_byte);
                default: nxt = cur;
            endcase
        end else if (tick) begin
            nxt = adv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= TIME_RESET;
        else     cur <= nxt;
    end

    assign now = cur;

    assert_sec_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en && cur.sec == 6'd59) |=> (cur.sec == 6'd0));

    assert_time_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(cur));

endmodule

// File: rtl/rtc_ptr_unit.sv
module rtc_ptr_unit #(
    parameter int NREGS = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(NREGS),
    localparam int FW   = DW - AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_wr,
    input  logic          start_rd,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [AW-1:0] ptr,
    output logic [FW-1:0] fmt,
    output logic          data_wr,
    output logic          rd_go
);

    localparam logic [AW-1:0] LAST = AW'(NREGS - 1);

    logic addr_pend;
    logic addr_take;

    // one bus event per cycle; a start outranks bytes, a write outranks a read
    assign addr_take = wr_valid && addr_pend && !start_rd && !start_wr;
    assign data_wr   = wr_valid && !addr_pend && !start_rd && !start_wr;
    assign rd_go     = rd_req && !wr_valid && !start_rd && !start_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= '0;
            fmt       <= '0;
            addr_pend <= 1'b0;
        end else if (start_rd) begin
            ptr <= LAST;
        end else if (start_wr) begin
            addr_pend <= 1'b1;
        end else if (addr_take) begin
            ptr       <= wr_data[DW-1 -: AW];
            fmt       <= wr_data[FW-1:0];
            addr_pend <= 1'b0;
        end else if (data_wr || rd_go) begin
            ptr <= ptr + AW'(1);
        end
    end

    assert_rdstart_ptr_R3: assert property (@(posedge clk) disable iff (rst)
        start_rd |=> (ptr == LAST));

    assert_ptr_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_valid && !start_rd && !start_wr && ptr == LAST) |=> (ptr == '0));

    assert_addr_load_R2: assert property (@(posedge clk) disable iff (rst)
        addr_take |=> (ptr == $past(wr_data[DW-1 -: AW])));

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile #(
    parameter int NREGS    = 16,
    parameter int DW       = 8,
    parameter int MODE_REG = 15,
    parameter int MODE_BIT = 5,
    localparam int AW      = $clog2(NREGS),
    localparam int FW      = DW - AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sec_tick,
    input  logic          start_wr,
    input  logic          start_rd,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic [FW-1:0] xfer_fmt
);
    import rtc_pkg::*;

    logic [AW-1:0] ptr;
    logic          data_wr;
    logic          rd_go;
    logic [DW-1:0] regs [NREGS];
    rtc_time_t     now;
    time_bytes_t   snap;
    logic          mode24;
    logic          time_wr;

    assign mode24  = regs[MODE_REG][MODE_BIT];
    assign time_wr = data_wr && (int'(ptr) < NUM_TIME);
    assign snap    = pack_time(now, mode24);

    rtc_ptr_unit #(.NREGS(NREGS), .DW(DW)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .ptr      (ptr),
        .fmt      (xfer_fmt),
        .data_wr  (data_wr),
        .rd_go    (rd_go)
    );

    rtc_timekeeper u_time (
        .clk     (clk),
        .rst     (rst),
        .tick    (sec_tick),
        .wr_en   (time_wr),
        .wr_sel  (ptr[2:0]),
        .wr_byte (wr_data),
        .mode24  (mode24),
        .now     (now)
    );

    // entries below NUM_TIME are read-start shadows, the rest are storage
    for (genvar i = 0; i < NREGS; i++) begin : g_entry
        if (i < NUM_TIME) begin : g_shadow
            always_ff @(posedge clk) begin
                if (rst)           regs[i] <= '0;
                else if (start_rd) regs[i] <= snap[i];
            end
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (rst)                                 regs[i] <= '0;
                else if (data_wr && ptr == AW'(i))       regs[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
            if (rd_go) rd_data <= regs[ptr];
        end
    end

    assert_rd_latency_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_valid && !start_rd && !start_wr) |=> rd_valid);

    assert_store_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_valid) |=> $stable(regs[MODE_REG]));

    assert_shadow_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!start_rd) |=> $stable(regs[0]));

endmodule

// File: tb/rtc_regfile_bench.sv
module rtc_regfile_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       start_wr = 1'b0;
    logic       start_rd = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data  = 8'h00;
    logic       rd_req   = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [3:0] xfer_fmt;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    rtc_regfile u_rtc_regfile (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .start_wr (start_wr),
        .start_rd (start_rd),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .xfer_fmt (xfer_fmt)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // monitor: every returned byte is compared with the next expected item
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) chk("R12 unexpected byte", rd_data, 8'hxx);
            else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic pulse_wr_start();
        @(negedge clk); start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;
    endtask

    task automatic pulse_rd_start();
        @(negedge clk); start_rd = 1'b1; @(negedge clk); start_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); wr_valid = 1'b1; wr_data = b;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic read_exp(input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk); rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); sec_tick = 1'b1; @(negedge clk); sec_tick = 1'b0;
        end
    endtask

    task automatic write_reg(input logic [3:0] idx, input logic [7:0] d);
        pulse_wr_start();
        send({idx, 4'h0});
        send(d);
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, wd, md, mo, y);
        pulse_wr_start();
        send(8'h00);
        send(s); send(mi); send(h); send(wd); send(md); send(mo); send(y);
    endtask

    task automatic read_time(input logic [7:0] r15, s, mi, h, wd, md, mo, y,
                             input string tag);
        pulse_rd_start();
        read_exp(r15, {tag, " R3 entry15 first"});
        read_exp(s,   {tag, " R5 sec"});
        read_exp(mi,  {tag, " R5 min"});
        read_exp(h,   {tag, " hour"});
        read_exp(wd,  {tag, " R8 wday"});
        read_exp(md,  {tag, " R5 mday"});
        read_exp(mo,  {tag, " R5 month"});
        read_exp(y,   {tag, " R5 year"});
    endtask

    task automatic check_hour(input logic [7:0] r15, input logic [7:0] h, input string tag);
        pulse_rd_start();
        read_exp(r15, {tag, " mode byte"});
        pulse_wr_start();
        send(8'h20);
        read_exp(h, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 rd_valid after reset", {7'b0, rd_valid}, 8'h00);
        chk("R11 xfer_fmt after reset", {4'b0, xfer_fmt}, 8'h00);
        // R11/R7: reset time, 12-hour mode, midnight reads 0x12
        read_time(8'h00, 8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h00, "R11 reset time R7");

        // R2: address byte loads pointer and format, writes nothing
        pulse_wr_start();
        send(8'h7A);
        chk("R2 xfer_fmt", {4'b0, xfer_fmt}, 8'h0A);
        pulse_wr_start();
        send(8'h70);
        read_exp(8'h00, "R2 entry7 untouched by address byte");

        // R9/R1/R6: fill storage, wrap into time registers
        pulse_wr_start();
        send(8'h7B);
        send(8'h55); send(8'hA8);
        for (int k = 9; k < 15; k++) send(8'(k));
        send(8'h20);
        send(8'h45); send(8'h59); send(8'h23); send(8'h07);
        send(8'h28); send(8'h02); send(8'h23);
        read_time(8'h20, 8'h45, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23, "R1 R6 write wrap");
        read_exp(8'h55, "R9 entry7");
        read_exp(8'hA8, "R9 entry8");
        for (int k = 9; k < 15; k++) read_exp(8'(k), "R9 entry9-14");
        read_exp(8'h20, "R9 entry15");
        read_exp(8'h45, "R1 read wrap to entry0");

        // R10/R8: end of Feb 28 in a common year, weekday 7 -> 1
        pulse_wr_start(); send(8'h00); send(8'h59);
        tick_n(1);
        read_time(8'h20, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23, "R10 common Feb R8");

        // R4: snapshot holds through ticks and a time write
        tick_n(5);
        pulse_wr_start(); send(8'h00); send(8'h30);
        pulse_wr_start(); send(8'h00);
        read_exp(8'h00, "R4 shadow unchanged");
        pulse_rd_start();
        read_exp(8'h20, "R4 mode byte");
        read_exp(8'h30, "R4 new snapshot");

        // R7/R6: hour formats, write in one form and read in the other
        write_reg(4'hF, 8'h00);
        write_reg(4'h2, 8'h32);
        check_hour(8'h00, 8'h32, "R7 noon 12h");
        write_reg(4'h2, 8'h12);
        check_hour(8'h00, 8'h12, "R7 midnight 12h");
        write_reg(4'hF, 8'h20);
        check_hour(8'h20, 8'h00, "R7 midnight as 24h");
        write_reg(4'hF, 8'h00);
        write_reg(4'h2, 8'h21);
        write_reg(4'hF, 8'h20);
        check_hour(8'h20, 8'h13, "R7 1PM as 24h");
        write_reg(4'h2, 8'hE3);
        check_hour(8'h20, 8'h23, "R6 mask 24h hour");
        write_reg(4'hF, 8'h00);
        check_hour(8'h00, 8'h31, "R7 23h as 12h");
        write_reg(4'h2, 8'h09);
        write_reg(4'hF, 8'h20);
        check_hour(8'h20, 8'h09, "R7 morning hour");

        // R5: write masks
        set_time(8'hD9, 8'hC0, 8'h10, 8'h02, 8'hC5, 8'hE9, 8'h50);
        read_time(8'h20, 8'h59, 8'h40, 8'h10, 8'h02, 8'h05, 8'h09, 8'h50, "R5 masks");

        // R10: minute carry without hour change
        set_time(8'h59, 8'h10, 8'h05, 8'h02, 8'h05, 8'h09, 8'h50);
        tick_n(1);
        read_time(8'h20, 8'h00, 8'h11, 8'h05, 8'h02, 8'h05, 8'h09, 8'h50, "R10 minute carry");

        // R10: leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        tick_n(1);
        read_time(8'h20, 8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24, "R10 leap Feb");

        // R10: 30-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h24);
        tick_n(1);
        read_time(8'h20, 8'h00, 8'h00, 8'h00, 8'h02, 8'h01, 8'h05, 8'h24, "R10 April end");

        // R10/R8: year 99 rollover
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        tick_n(1);
        read_time(8'h20, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R10 year wrap R8");

        repeat (4) @(negedge clk);
        chk("R12 all reads returned", 8'(exp_q.size()), 8'h00);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule